// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Datapath

This unit is a 32-bit integer execution block for a group of multiply-accumulate operations on a 32-bit core. Each operation takes two source operands, the destination register's current value (used as the accumulator), a 5-bit shift immediate and a 5-bit operation select. It returns one 32-bit result.

Two operations work on full words. One adds the low 32 bits of the product to the accumulator, and the other subtracts those bits from the accumulator. The other sixteen operations each pick the lower or upper halves of both sources and extend them as signed or unsigned values. They form the product and may add the accumulator. They may also add a round-to-nearest constant. The sum then goes through a right shift by the immediate.

The unit is pipelined over two register stages. An operation is accepted on any rising edge where `inVld` and `inRdy` are both high. Its result appears with a one-cycle `outVld` pulse, and results leave in the order the operations were accepted. Decoding, register file access and hazard handling are done outside this unit.

Top module: `halfmac_top`

## Requirements
- R1: With opSel = 5'b0xxx0 (bit 4 clear, bit 0 clear) the result is accIn + (srcA * srcB) mod 2^32.
- R2: With opSel = 5'b0xxx1 (bit 4 clear, bit 0 set) the result is accIn - (srcA * srcB) mod 2^32.
- R3: With opSel bit 4 set, opSel bit 2 chooses the operand halves. A value of 0 takes bits 15:0 of both sources, and a value of 1 takes bits 31:16 of both sources.
- R4: With opSel bit 4 set, opSel bit 1 = 1 sign-extends both halves and shifts right arithmetically. A value of 0 zero-extends both halves and shifts right logically.
- R5: With opSel bit 4 set, the result is (product of the extended halves, plus accIn when opSel bit 3 is set) shifted right by shamt.
- R6: With opSel bits 4 and 0 both set and shamt = N > 0, the constant 2^(N-1) is added to the sum before the shift. When N = 0, nothing is added.
- R7: Every intermediate sum wraps modulo 2^32 before the shift. No saturation is applied.
- R8: An operation accepted at the rising edge that ends cycle t is reported in cycle t+2 with outVld high for exactly that cycle. Operations may be accepted on consecutive cycles, and results come back in acceptance order.
- R9: While rstN is low, outVld, inRdy and result are all 0. From the first rising edge after reset is released, inRdy is 1 and stays at 1.
- R10: With opSel bit 4 clear, opSel bits 3:1 and shamt have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inVld | input | 1 | An operation is offered |
| inRdy | output | 1 | The unit can accept an operation |
| opSel | input | 5 | Operation select (bit fields given in R1 to R6 and R10) |
| srcA | input | 32 | First source operand |
| srcB | input | 32 | Second source operand |
| accIn | input | 32 | Destination value used as the accumulator |
| shamt | input | 5 | Right shift immediate N, 0 to 31 |
| outVld | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | Result of the oldest outstanding operation |

## Verification
Every operation's result and valid pulse are due two cycles after the cycle in which it was offered and accepted. The first register stage holds the product, and the second holds the shifted sum. The bench drives inputs and samples outputs on the falling edge. It tags each accepted operation with its due cycle in a queue, and on every cycle it compares outVld with whether the head of the queue is due. On a valid cycle it also compares result with the reference value. A result that comes late, early or out of order therefore shows up either as a valid mismatch or as a data mismatch. The stimulus mixes back-to-back and gapped issue, random operands, all 32 shift values, and directed corner operands.

// File: rtl/halfmac_pkg.sv
package halfmac_pkg;

  localparam int unsigned OP_W = 5;

  // field positions inside the operation select
  localparam int unsigned OP_HALF_BIT  = 4;
  localparam int unsigned OP_ACC_BIT   = 3;
  localparam int unsigned OP_HIGH_BIT  = 2;
  localparam int unsigned OP_SIGN_BIT  = 1;
  localparam int unsigned OP_ROUND_BIT = 0;  // doubles as subtract flag for full-word ops

  typedef struct packed {
    logic s1Load;   // capture operands into stage 1
    logic s2Load;   // capture final sum into stage 2
  } strobe_t;

  typedef struct packed {
    logic isHalf;
    logic accum;
    logic hiSel;
    logic sgn;
    logic rnd;
    logic neg;
  } opdec_t;

  function automatic opdec_t decodeOp(input logic [OP_W-1:0] op);
    opdec_t d;
    d.isHalf = op[OP_HALF_BIT];
    d.accum  = op[OP_HALF_BIT] & op[OP_ACC_BIT];
    d.hiSel  = op[OP_HALF_BIT] & op[OP_HIGH_BIT];
    d.sgn    = op[OP_HALF_BIT] & op[OP_SIGN_BIT];
    d.rnd    = op[OP_HALF_BIT] & op[OP_ROUND_BIT];
    d.neg    = ~op[OP_HALF_BIT] & op[OP_ROUND_BIT];
    return d;
  endfunction

endpackage

// File: rtl/halfmac_ctrl.sv
module halfmac_ctrl
  import halfmac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inVld,
  output logic    inRdy,
  output strobe_t strb,
  output logic    outVld
);

  logic readyQ;
  logic stage1VldQ;
  logic stage2VldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ     <= 1'b0;
      stage1VldQ <= 1'b0;
      stage2VldQ <= 1'b0;
    end else begin
      readyQ     <= 1'b1;
      stage1VldQ <= inVld & readyQ;
      stage2VldQ <= stage1VldQ;
    end
  end

  assign inRdy       = readyQ;
  assign strb.s1Load = inVld & readyQ;
  assign strb.s2Load = stage1VldQ;
  assign outVld      = stage2VldQ;

  // accepted operation must show up two edges later
  p_result_due_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inRdy) |=> ##1 outVld);

  // a valid pulse needs a stage-2 load on the edge before
  p_valid_has_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> $past(strb.s2Load));

  // once ready, stays ready
  p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(inRdy) |-> inRdy);

endmodule

// File: rtl/halfmac_dp.sv
module halfmac_dp
  import halfmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [OP_W-1:0]           opSel,
  input  logic [DATA_W-1:0]         srcA,
  input  logic [DATA_W-1:0]         srcB,
  input  logic [DATA_W-1:0]         accIn,
  input  logic [$clog2(DATA_W)-1:0] shamt,
  output logic [DATA_W-1:0]         result
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned SH_W   = $clog2(DATA_W);

  opdec_t              dec;
  logic [HALF_W-1:0]   halfA, halfB;
  logic [DATA_W-1:0]   extA, extB;
  logic [DATA_W-1:0]   mulA, mulB;
  logic [DATA_W-1:0]   prodNext;
  logic [DATA_W-1:0]   roundConst;
  logic [DATA_W-1:0]   addNext;
  logic [SH_W-1:0]     shNext;

  logic [DATA_W-1:0]   prodQ, addQ;
  logic [SH_W-1:0]     shQ;
  logic                sgnQ, negQ, halfQ;

  logic [DATA_W-1:0]   sumS2;
  logic [DATA_W-1:0]   shiftedS2;
  logic [DATA_W-1:0]   resultQ;

  // ---------------- stage 1: select, extend, multiply
  always_comb begin
    dec   = decodeOp(opSel);
    halfA = dec.hiSel ? srcA[DATA_W-1:HALF_W] : srcA[HALF_W-1:0];
    halfB = dec.hiSel ? srcB[DATA_W-1:HALF_W] : srcB[HALF_W-1:0];
    extA  = {{HALF_W{dec.sgn & halfA[HALF_W-1]}}, halfA};
    extB  = {{HALF_W{dec.sgn & halfB[HALF_W-1]}}, halfB};
    mulA  = dec.isHalf ? extA : srcA;
    mulB  = dec.isHalf ? extB : srcB;
    prodNext = mulA * mulB;

    roundConst = '0;
    if (dec.rnd && (shamt != '0))
      roundConst = {{(DATA_W-1){1'b0}}, 1'b1} << (shamt - 1'b1);

    if (dec.isHalf)
      addNext = (dec.accum ? accIn : '0) + roundConst;
    else
      addNext = accIn;

    shNext = dec.isHalf ? shamt : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      addQ  <= '0;
      shQ   <= '0;
      sgnQ  <= 1'b0;
      negQ  <= 1'b0;
      halfQ <= 1'b0;
    end else if (strb.s1Load) begin
      prodQ <= prodNext;
      addQ  <= addNext;
      shQ   <= shNext;
      sgnQ  <= dec.sgn;
      negQ  <= dec.neg;
      halfQ <= dec.isHalf;
    end
  end

  // ---------------- stage 2: accumulate, shift
  always_comb begin
    sumS2 = negQ ? (addQ - prodQ) : (addQ + prodQ);
    if (sgnQ)
      shiftedS2 = DATA_W'($signed(sumS2) >>> shQ);
    else
      shiftedS2 = sumS2 >> shQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      resultQ <= '0;
    else if (strb.s2Load)
      resultQ <= shiftedS2;
  end

  assign result = resultQ;

  // unsigned halfword product with no addend, shifted by at least one, fits below the top bit
  p_unsigned_msb_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && halfQ && !sgnQ && (addQ == '0) && (shQ != '0)) |=> !result[DATA_W-1]);

  // subtract from zero gives the negated product
  p_msu_negates_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && negQ && (addQ == '0)) |=> (result == DATA_W'(-$past(prodQ))));

  // no shift and no addend passes the stage-1 product straight through
  p_zero_shift_product_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && halfQ && (shQ == '0) && (addQ == '0)) |=> (result == $past(prodQ)));

endmodule

// File: rtl/halfmac_top.sv
module halfmac_top
  import halfmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inVld,
  output logic                      inRdy,
  input  logic [OP_W-1:0]           opSel,
  input  logic [DATA_W-1:0]         srcA,
  input  logic [DATA_W-1:0]         srcB,
  input  logic [DATA_W-1:0]         accIn,
  input  logic [$clog2(DATA_W)-1:0] shamt,
  output logic                      outVld,
  output logic [DATA_W-1:0]         result
);

  strobe_t strb;

  halfmac_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .inRdy  (inRdy),
    .strb   (strb),
    .outVld (outVld)
  );

  halfmac_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opSel  (opSel),
    .srcA   (srcA),
    .srcB   (srcB),
    .accIn  (accIn),
    .shamt  (shamt),
    .result (result)
  );

endmodule

// File: tb/halfmac_top_tb.sv
`timescale 1ns/1ps
module halfmac_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inVld = 1'b0;
  logic        inRdy;
  logic [4:0]  opSel = '0;
  logic [31:0] srcA = '0, srcB = '0, accIn = '0;
  logic [4:0]  shamt = '0;
  logic        outVld;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] val;
    int          due;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  halfmac_top dut_i (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inRdy(inRdy), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .shamt(shamt),
    .outVld(outVld), .result(result)
  );

  function automatic logic [31:0] refModel(input logic [4:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] c,
                                           input logic [4:0] n);
    logic [15:0] ha, hb;
    logic [31:0] ea, eb, s;
    if (!op[4]) return op[0] ? (c - a * b) : (c + a * b);
    ha = op[2] ? a[31:16] : a[15:0];
    hb = op[2] ? b[31:16] : b[15:0];
    ea = op[1] ? {{16{ha[15]}}, ha} : {16'h0, ha};
    eb = op[1] ? {{16{hb[15]}}, hb} : {16'h0, hb};
    s  = ea * eb;
    if (op[3]) s = s + c;
    if (op[0] && n != 0) s = s + (32'd1 << (n - 1));
    return op[1] ? 32'($signed(s) >>> n) : (s >> n);
  endfunction

  function automatic string tagFor(input logic [4:0] op);
    if (!op[4]) return op[0] ? "R2" : "R1";
    if (op[0]) return "R6";
    if (op[3]) return "R5";
    if (op[1]) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycle);
    end
  endtask

  // per-cycle output check, then drive; everything on the falling edge
  task automatic step(input bit vld, input logic [4:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input logic [4:0] n,
                      input string tag);
    exp_t e;
    bit due;
    @(negedge clk);
    cycle++;
    due = (expQ.size() > 0) && (expQ[0].due == cycle);
    check("R8 valid", {31'd0, outVld}, {31'd0, due});
    if (due) begin
      e = expQ.pop_front();
      check(e.tag, result, e.val);
    end
    inVld = vld; opSel = op; srcA = a; srcB = b; accIn = c; shamt = n;
    if (vld && inRdy) begin
      e.val = refModel(op, a, b, c, n);
      e.due = cycle + 2;
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [4:0] n, input string tag);
    step(1'b1, op, a, b, c, n, tag);
  endtask

  task automatic idle();
    step(1'b0, 5'd0, 32'd0, 32'd0, 32'd0, 5'd0, "idle");
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [4:0] op;
    int unsigned seed;
    seed = 32'h1234abcd;
    void'($urandom(seed));

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 outVld in reset", {31'd0, outVld}, 32'd0);
    check("R9 inRdy in reset", {31'd0, inRdy}, 32'd0);
    check("R9 result in reset", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 inRdy after reset", {31'd0, inRdy}, 32'd1);

    // directed corners
    issue(5'b00000, 32'h0001_0003, 32'h0000_0005, 32'h0000_0010, 5'd0, "R1");
    issue(5'b00001, 32'h0000_0007, 32'h0000_0003, 32'h0000_0020, 5'd0, "R2");
    issue(5'b00000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R7");
    issue(5'b01110, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1111_1111, 5'd13, "R10");
    issue(5'b00111, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1111_1111, 5'd31, "R10");
    issue(5'b10000, 32'hAAAA_0003, 32'h5555_0004, 32'h0, 5'd0, "R3");
    issue(5'b10100, 32'h0003_AAAA, 32'h0004_5555, 32'h0, 5'd0, "R3");
    issue(5'b10010, 32'h0000_8000, 32'h0000_8000, 32'h0, 5'd0, "R4");
    issue(5'b10000, 32'h0000_8000, 32'h0000_FFFF, 32'h0, 5'd0, "R4");
    issue(5'b10010, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 5'd31, "R4");
    issue(5'b10000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0, 5'd31, "R4");
    issue(5'b11010, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 5'd4, "R5");
    issue(5'b11000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0002_0000, 5'd0, "R7");
    issue(5'b10001, 32'h0000_0003, 32'h0000_0001, 32'h0, 5'd1, "R6");
    issue(5'b10001, 32'h0000_0003, 32'h0000_0001, 32'h0, 5'd0, "R6");
    issue(5'b10011, 32'h0000_8000, 32'h0000_7FFF, 32'h0, 5'd31, "R6");
    issue(5'b11111, 32'hFFFF_0000, 32'h8000_0000, 32'hFFFF_FFFF, 5'd31, "R6");
    issue(5'b11001, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 5'd16, "R7");
    idle(); idle(); idle();

    // every shift value across the halfword operations
    for (int n = 0; n < 32; n++) begin
      for (int k = 0; k < 16; k++) begin
        op = {1'b1, 4'(k)};
        issue(op, $urandom(), $urandom(), $urandom(), 5'(n), tagFor(op));
      end
    end

    // random mix with gaps
    for (int i = 0; i < 600; i++) begin
      if (($urandom() % 5) == 0) idle();
      else begin
        op = 5'($urandom() % 32);
        issue(op, $urandom(), $urandom(), $urandom(), 5'($urandom()), tagFor(op));
      end
    end

    repeat (4) idle();
    check("R8 queue drained", expQ.size(), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule